// File: doc/BRIEF.md
# Synthesizer Channel and Settling Sequencer

This block sits between the radio's control registers and the frequency synthesizer. It holds the channel number, turns it into a synthesizer target frequency in kHz, and steps through the radio's timed state changes. These are power-up with calibration, retuning to a new channel, the move up to the transmit frequency, and the return to the receive frequency. All settling delays are counted in microsecond ticks from a free-running tick input, so no real loop is measured.

After a power-up or channel change, the block asks the calibration engine to run and waits for its completion strobe. It then reports the synthesizer as settled and raises a lock interrupt. A channel change made while locked also raises an unlock interrupt. The receive and transmit frequencies of a channel are 1 MHz apart, so starting and ending a transmission means a short retune. Those retunes drop the settled flag for a fixed time, but they never raise either interrupt.

Top module: `pll_freq_seq`

## Requirements
- R1: Channel codes 3 through 10 select a transmit frequency of 910000 + 2000*(code-3) kHz. `freq_khz` shows this value while a transmission is starting or running.
- R2: In every other state, `freq_khz` is 1000 kHz below the transmit frequency of the current channel. After reset the channel is 3, `freq_khz` is 909000 and `settled` is 0.
- R3: A channel write (`chan_we`) with a code of 0 to 2 or 11 to 255 is ignored, and the previous channel stays in force.
- R4: In the off state, `req_pll_on` or `req_rx` starts the power-up. It gives a one-cycle `cal_start` pulse, and `settled` stays 0 until `cal_done` arrives. Then `settled` goes to 1, and `irq_lock` pulses if enabled.
- R5: In the locked state, `req_tx_start` moves `freq_khz` to the transmit frequency and clears `settled` for exactly 16 ticks. `settled` then returns to 1.
- R6: During a transmission, `req_tx_end` moves `freq_khz` back to the receive frequency and clears `settled` for exactly 32 ticks. `settled` then returns to 1.
- R7: Neither `irq_lock` nor `irq_unlock` pulses during the retunes of R5 and R6.
- R8: A valid channel write that differs from the current channel, made while locked, has three effects. It pulses `cal_start`, it pulses `irq_unlock` if enabled, and it clears `settled`. `settled` and the `irq_lock` pulse return only when both 11 ticks have passed and `cal_done` has been seen.
- R9: With `lock_irq_en` low no `irq_lock` pulse is issued, and with `unlock_irq_en` low no `irq_unlock` pulse is issued. Each issued pulse lasts one cycle.
- R10: `req_off` returns the block to the off state from any state, with `settled` 0. It takes priority over any other request in the same cycle.
- R11: Channel writes are ignored while a transmission is starting, running or ending. A write of the code already in use starts no calibration.
- R12: `req_tx_start` and `cal_done` have no effect in the off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| chan_we | input | 1 | Channel write strobe |
| chan_code | input | 8 | Channel code written |
| req_off | input | 1 | Request off state |
| req_pll_on | input | 1 | Request synthesizer on |
| req_rx | input | 1 | Request receive |
| req_tx_start | input | 1 | Request start of transmission |
| req_tx_end | input | 1 | Request end of transmission |
| cal_done | input | 1 | Calibration finished strobe |
| lock_irq_en | input | 1 | Lock interrupt enable |
| unlock_irq_en | input | 1 | Unlock interrupt enable |
| freq_khz | output | 20 | Synthesizer target frequency in kHz |
| settled | output | 1 | Synthesizer settled at the target |
| cal_start | output | 1 | One-cycle calibration request |
| irq_lock | output | 1 | One-cycle lock interrupt |
| irq_unlock | output | 1 | One-cycle unlock interrupt |

## Verification
A corrupted channel register appears on `freq_khz` one cycle after the corruption, and stays there until the next accepted write. A settle counter that loads the wrong value or misses a tick moves the rise of `settled` away from exactly 16, 32 or 11 ticks after the request. A state register that confuses the retune states with calibration shows up as a stray lock or unlock pulse within a cycle of the transition. A fault that skips calibration shows up as `settled` rising before `cal_done`.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF = 3'd0,
    ST_CAL = 3'd1,
    ST_ON  = 3'd2,
    ST_TXS = 3'd3,
    ST_TX  = 3'd4,
    ST_TXB = 3'd5
  } seq_state_t;
endpackage

// File: rtl/pll_chan_reg.sv
module pll_chan_reg #(
  parameter int CW     = 8,
  parameter int CH_LO  = 3,
  parameter int CH_HI  = 10,
  parameter int CH_RST = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          allow,
  input  logic [CW-1:0] code,
  output logic [CW-1:0] ch,
  output logic          accept
);
  logic [CW-1:0] ch_q;
  logic          code_ok;

  assign code_ok = (code >= CW'(CH_LO)) && (code <= CW'(CH_HI));
  assign accept  = we && allow && code_ok && (code != ch_q);
  assign ch      = ch_q;

  always_ff @(posedge clk) begin
    if (rst)         ch_q <= CW'(CH_RST);
    else if (accept) ch_q <= code;
  end

  // R3: reserved codes leave the channel untouched
  a_r3_reserved_kept: assert property (@(posedge clk) disable iff (rst)
    (we && !code_ok) |=> $stable(ch_q));
  // R1: channel always inside the mapped range
  a_r1_ch_in_range: assert property (@(posedge clk) disable iff (rst)
    (ch_q >= CW'(CH_LO)) && (ch_q <= CW'(CH_HI)));
  // R11: disallowed writes leave the channel untouched
  a_r11_blocked_kept: assert property (@(posedge clk) disable iff (rst)
    (we && !allow) |=> $stable(ch_q));
endmodule

// File: rtl/pll_settle_timer.sv
module pll_settle_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R5: a load sets the count to the requested delay
  a_r5_load_value: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
  // R6: an expired count never wraps around
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero);
endmodule

// File: rtl/pll_freq_map.sv
module pll_freq_map #(
  parameter int CW     = 8,
  parameter int FW     = 20,
  parameter int BASE   = 910000,
  parameter int STEP   = 2000,
  parameter int OFS    = 1000,
  parameter int CH_LO  = 3,
  parameter int CH_RST = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ch,
  input  logic          tx_sel,
  output logic [FW-1:0] freq
);
  localparam int RST_KHZ = BASE + (CH_RST - CH_LO) * STEP - OFS;

  logic [31:0] khz_full;
  logic [FW-1:0] freq_q;

  assign khz_full = 32'(BASE) + (32'(ch) - 32'(CH_LO)) * 32'(STEP)
                  - (tx_sel ? 32'd0 : 32'(OFS));

  always_ff @(posedge clk) begin
    if (rst) freq_q <= FW'(RST_KHZ);
    else     freq_q <= khz_full[FW-1:0];
  end

  assign freq = freq_q;

  // R2: moving to transmit on a fixed channel raises the word by the offset
  a_r2_tx_offset: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_sel) && $stable(ch)) |=> (freq_q == $past(freq_q) + FW'(OFS)));
endmodule

// File: rtl/pll_freq_seq.sv
module pll_freq_seq #(
  parameter int CW      = 8,
  parameter int FW      = 20,
  parameter int BASE    = 910000,
  parameter int STEP    = 2000,
  parameter int OFS     = 1000,
  parameter int CH_LO   = 3,
  parameter int CH_HI   = 10,
  parameter int CH_RST  = 3,
  parameter int T_RXTX  = 16,
  parameter int T_TXRX  = 32,
  parameter int T_CHSW  = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_us,
  input  logic          chan_we,
  input  logic [CW-1:0] chan_code,
  input  logic          req_off,
  input  logic          req_pll_on,
  input  logic          req_rx,
  input  logic          req_tx_start,
  input  logic          req_tx_end,
  input  logic          cal_done,
  input  logic          lock_irq_en,
  input  logic          unlock_irq_en,
  output logic [FW-1:0] freq_khz,
  output logic          settled,
  output logic          cal_start,
  output logic          irq_lock,
  output logic          irq_unlock
);
  import pll_seq_pkg::*;

  localparam int T_MAX1 = (T_RXTX > T_TXRX) ? T_RXTX : T_TXRX;
  localparam int T_MAX  = (T_MAX1 > T_CHSW) ? T_MAX1 : T_CHSW;
  localparam int TW     = $clog2(T_MAX + 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] ch;
  logic          ch_acc, ch_allow;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          cal_go, lock_go, unlock_go;
  logic          cal_seen_q;
  logic          settled_q, cal_start_q, irq_lock_q, irq_unlock_q;
  logic          tx_sel;

  assign ch_allow = (state_q == ST_OFF) || (state_q == ST_CAL) || (state_q == ST_ON);
  assign tx_sel   = (state_q == ST_TXS) || (state_q == ST_TX);

  pll_chan_reg #(.CW(CW), .CH_LO(CH_LO), .CH_HI(CH_HI), .CH_RST(CH_RST)) u_chan (
    .clk(clk), .rst(rst), .we(chan_we), .allow(ch_allow), .code(chan_code),
    .ch(ch), .accept(ch_acc)
  );

  pll_settle_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .tick(tick_us),
    .zero(t_zero)
  );

  pll_freq_map #(.CW(CW), .FW(FW), .BASE(BASE), .STEP(STEP), .OFS(OFS),
                 .CH_LO(CH_LO), .CH_RST(CH_RST)) u_map (
    .clk(clk), .rst(rst), .ch(ch), .tx_sel(tx_sel), .freq(freq_khz)
  );

  always_comb begin
    state_d   = state_q;
    t_load    = 1'b0;
    t_val     = '0;
    cal_go    = 1'b0;
    lock_go   = 1'b0;
    unlock_go = 1'b0;
    if (req_off) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF: if (req_pll_on || req_rx) begin
          state_d = ST_CAL;
          t_load  = 1'b1;
          cal_go  = 1'b1;
        end
        ST_CAL: if (ch_acc) begin
          t_load = 1'b1;
          t_val  = TW'(T_CHSW);
          cal_go = 1'b1;
        end else if ((cal_done || cal_seen_q) && t_zero) begin
          state_d = ST_ON;
          lock_go = 1'b1;
        end
        ST_ON: if (ch_acc) begin
          state_d   = ST_CAL;
          t_load    = 1'b1;
          t_val     = TW'(T_CHSW);
          cal_go    = 1'b1;
          unlock_go = 1'b1;
        end else if (req_tx_start) begin
          state_d = ST_TXS;
          t_load  = 1'b1;
          t_val   = TW'(T_RXTX);
        end
        ST_TXS: if (t_zero) state_d = ST_TX;
        ST_TX: if (req_tx_end) begin
          state_d = ST_TXB;
          t_load  = 1'b1;
          t_val   = TW'(T_TXRX);
        end
        ST_TXB: if (t_zero) state_d = ST_ON;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_OFF;
      cal_seen_q   <= 1'b0;
      settled_q    <= 1'b0;
      cal_start_q  <= 1'b0;
      irq_lock_q   <= 1'b0;
      irq_unlock_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      settled_q    <= (state_d == ST_ON) || (state_d == ST_TX);
      cal_start_q  <= cal_go;
      irq_lock_q   <= lock_go && lock_irq_en;
      irq_unlock_q <= unlock_go && unlock_irq_en;
      if (t_load || state_q != ST_CAL) cal_seen_q <= 1'b0;
      else if (cal_done)               cal_seen_q <= 1'b1;
    end
  end

  assign settled    = settled_q;
  assign cal_start  = cal_start_q;
  assign irq_lock   = irq_lock_q;
  assign irq_unlock = irq_unlock_q;

  // R7: no interrupt pulses while in the transmit retune states
  a_r7_quiet_retune: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TXS || state_q == ST_TX || state_q == ST_TXB) |-> (!irq_lock_q && !irq_unlock_q));
  // R9: interrupt pulses last a single cycle
  a_r9_lock_single: assert property (@(posedge clk) disable iff (rst)
    irq_lock_q |=> !irq_lock_q);
  a_r9_unlock_single: assert property (@(posedge clk) disable iff (rst)
    irq_unlock_q |=> !irq_unlock_q);
  // R9: a disabled interrupt never pulses
  a_r9_lock_gated: assert property (@(posedge clk) disable iff (rst)
    !lock_irq_en |=> !irq_lock_q);
  // R10: an off request always drops the settled flag
  a_r10_off_prio: assert property (@(posedge clk) disable iff (rst)
    req_off |=> !settled_q);
  // R4: calibration request is a single-cycle pulse
  a_r4_cal_single: assert property (@(posedge clk) disable iff (rst)
    cal_start_q |=> !cal_start_q);
endmodule

// File: tb/pll_freq_seq_tb.sv
module pll_freq_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_us = 0, chan_we = 0, req_off = 0, req_pll_on = 0, req_rx = 0;
  logic        req_tx_start = 0, req_tx_end = 0, cal_done = 0;
  logic        lock_irq_en = 1, unlock_irq_en = 1;
  logic [7:0]  chan_code = 8'd0;
  logic [19:0] freq_khz;
  logic        settled, cal_start, irq_lock, irq_unlock;

  int checks = 0, errors = 0;
  int n_lock = 0, n_unlock = 0, n_cal = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pll_freq_seq u_dut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .chan_we(chan_we), .chan_code(chan_code),
    .req_off(req_off), .req_pll_on(req_pll_on), .req_rx(req_rx),
    .req_tx_start(req_tx_start), .req_tx_end(req_tx_end), .cal_done(cal_done),
    .lock_irq_en(lock_irq_en), .unlock_irq_en(unlock_irq_en),
    .freq_khz(freq_khz), .settled(settled), .cal_start(cal_start),
    .irq_lock(irq_lock), .irq_unlock(irq_unlock)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (irq_lock)   n_lock++;
      if (irq_unlock) n_unlock++;
      if (cal_start)  n_cal++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us = 1; step(1); tick_us = 0; step(2);
    end
  endtask

  task automatic write_ch(input int c);
    chan_code = 8'(c); chan_we = 1; step(1); chan_we = 0; step(2);
  endtask

  task automatic pulse_cal_done();
    cal_done = 1; step(1); cal_done = 0; step(2);
  endtask

  task automatic test_reset();
    chk("R2 reset freq", int'(freq_khz), 909000);
    chk("R2 reset settled", int'(settled), 0);
  endtask

  task automatic test_power_up();
    int l0 = n_lock, c0 = n_cal;
    req_rx = 1; step(1); req_rx = 0; step(2);
    chk("R4 cal_start pulse", n_cal - c0, 1);
    ticks(3);
    chk("R4 settled waits for cal_done", int'(settled), 0);
    pulse_cal_done();
    chk("R4 settled after cal", int'(settled), 1);
    chk("R4 lock pulse", n_lock - l0, 1);
    chk("R2 rx freq ch3", int'(freq_khz), 909000);
  endtask

  task automatic test_reserved();
    int c0 = n_cal;
    write_ch(11);
    write_ch(2);
    chk("R3 reserved keeps freq", int'(freq_khz), 909000);
    chk("R3 reserved no cal", n_cal - c0, 0);
    chk("R3 reserved settled", int'(settled), 1);
  endtask

  task automatic test_chan_change();
    int l0 = n_lock, u0 = n_unlock, c0 = n_cal;
    write_ch(10);
    chk("R8 unlock pulse", n_unlock - u0, 1);
    chk("R8 cal_start pulse", n_cal - c0, 1);
    chk("R8 settled low", int'(settled), 0);
    chk("R2 rx freq ch10", int'(freq_khz), 923000);
    pulse_cal_done();
    ticks(10);
    chk("R8 settled waits 11 ticks", int'(settled), 0);
    ticks(1);
    chk("R8 settled after 11 ticks", int'(settled), 1);
    chk("R8 lock pulse", n_lock - l0, 1);
    c0 = n_cal;
    write_ch(10);
    chk("R11 same code no cal", n_cal - c0, 0);
    chk("R11 same code settled", int'(settled), 1);
  endtask

  task automatic test_tx();
    int l0 = n_lock, u0 = n_unlock;
    req_tx_start = 1; step(1); req_tx_start = 0; step(2);
    chk("R1 tx freq ch10", int'(freq_khz), 924000);
    chk("R5 settled low", int'(settled), 0);
    ticks(15);
    chk("R5 settled after 15", int'(settled), 0);
    ticks(1);
    chk("R5 settled after 16", int'(settled), 1);
    write_ch(5);
    chk("R11 write ignored in tx", int'(freq_khz), 924000);
    req_tx_end = 1; step(1); req_tx_end = 0; step(2);
    chk("R6 rx freq back", int'(freq_khz), 923000);
    ticks(31);
    chk("R6 settled after 31", int'(settled), 0);
    ticks(1);
    chk("R6 settled after 32", int'(settled), 1);
    chk("R7 no lock pulse", n_lock - l0, 0);
    chk("R7 no unlock pulse", n_unlock - u0, 0);
  endtask

  task automatic test_irq_disabled();
    int l0 = n_lock, u0 = n_unlock, c0 = n_cal;
    lock_irq_en = 0; unlock_irq_en = 0; step(1);
    write_ch(6);
    chk("R9 unlock gated", n_unlock - u0, 0);
    chk("R8 cal_start", n_cal - c0, 1);
    chk("R2 rx freq ch6", int'(freq_khz), 915000);
    pulse_cal_done();
    ticks(11);
    chk("R8 settled", int'(settled), 1);
    chk("R9 lock gated", n_lock - l0, 0);
    req_tx_start = 1; step(1); req_tx_start = 0; step(2);
    chk("R1 tx freq ch6", int'(freq_khz), 916000);
    ticks(16);
    req_tx_end = 1; step(1); req_tx_end = 0; step(2);
    ticks(32);
    lock_irq_en = 1; unlock_irq_en = 1; step(1);
  endtask

  task automatic test_off();
    int l0 = n_lock, c0 = n_cal;
    req_off = 1; req_tx_start = 1; step(1); req_off = 0; req_tx_start = 0; step(2);
    chk("R10 off priority settled", int'(settled), 0);
    chk("R10 off rx freq", int'(freq_khz), 915000);
    req_tx_start = 1; step(1); req_tx_start = 0; step(2);
    ticks(20);
    chk("R12 tx_start in off", int'(settled), 0);
    chk("R12 tx_start freq", int'(freq_khz), 915000);
    pulse_cal_done();
    chk("R12 cal_done in off", int'(settled), 0);
    chk("R12 no lock in off", n_lock - l0, 0);
    chk("R12 no cal in off", n_cal - c0, 0);
    req_pll_on = 1; step(1); req_pll_on = 0; step(2);
    pulse_cal_done();
    chk("R4 pll_on power-up", int'(settled), 1);
    req_tx_start = 1; step(1); req_tx_start = 0; step(2);
    ticks(5);
    req_off = 1; step(1); req_off = 0; step(2);
    ticks(20);
    chk("R10 off from tx settle", int'(settled), 0);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(2);
    test_reset();
    test_power_up();
    test_reserved();
    test_chan_change();
    test_tx();
    test_irq_disabled();
    test_off();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule